// File: doc/BRIEF.md
# Leading Zero and Leading One Counter

This unit is the bit-count execution path of a processor pipeline. Given an operand word and a function code, it reports how many consecutive bits, starting at the most significant end, equal zero (zero-count function) or equal one (one-count function). The caller supplies one source operand and receives one result word, which is written back to a destination register.

A single zero-count core serves both functions. For the one-count function the operand is inverted before it enters the core. Inside the core a halving search runs first. For a 32-bit word it tests the upper 16, then 8, then 4 bits of the remaining span. Each time the tested part is non-zero, the search drops the lower part and takes the tested width off a running length. A 4-bit significance lookup then finishes the count. The result, a validity flag and an illegal-function flag are held in one output register stage.

Top module: `lead_bit_counter`

## Requirements
- R1: With function code 32 and an all-zero operand, the result is 32.
- R2: With function code 33 and an all-ones operand, the result is 32.
- R3: Function code 32 returns the number of consecutive zero bits starting from bit 31 and moving downward, for any operand.
- R4: Function code 33 returns the number of consecutive one bits starting from bit 31 and moving downward, for any operand.
- R5: Result bits [31:6] are always zero, and the count sits in bits [5:0].
- R6: When valid is high with a function code other than 32 or 33, one cycle later the illegal flag is high and the result is zero.
- R7: The result-valid flag equals the valid input of the previous cycle, and the illegal flag stays low for codes 32 and 33.
- R8: In a cycle after valid was low, the result keeps its last value and the illegal flag is low.
- R9: While reset is high, the result, result-valid and illegal outputs are all zero from the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_valid_i | input | 1 | Operand and function code are valid |
| func_i | input | 6 | Function code: 32 counts zeros, 33 counts ones |
| operand_i | input | 32 | Source operand |
| result_o | output | 32 | Count, zero-extended |
| result_valid_o | output | 1 | Result is valid, one cycle after op_valid_i |
| illegal_o | output | 1 | The last accepted function code was not recognised |

## Verification
Because the search path is combinational and feeds one register, a wrong shift or a wrong length step in any halving stage shows up in result_o on the cycle right after the operand is presented. It only appears for operands whose first set bit falls in the span that stage decides. The single-bit sweep places the first set bit at every position, so each stage decision and each nibble lookup entry is reached in both functions. Errors in the inversion path or the decode show up on the same cycle, as a count swapped between the two functions or as a wrong illegal flag.

// File: rtl/lbc_pkg.sv
package lbc_pkg;
  localparam int unsigned LBC_DATA_W = 32;
  localparam int unsigned LBC_FUNC_W = 6;
  localparam logic [LBC_FUNC_W-1:0] LBC_FN_ZEROS = 6'd32;
  localparam logic [LBC_FUNC_W-1:0] LBC_FN_ONES  = 6'd33;

  typedef enum logic [1:0] {
    CNT_ZEROS = 2'd0,
    CNT_ONES  = 2'd1,
    CNT_BAD   = 2'd2
  } cnt_kind_e;
endpackage

// File: rtl/lbc_halve_stage.sv
module lbc_halve_stage #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 6,
  parameter int unsigned SPAN   = 32
) (
  input  logic [DATA_W-1:0] val_i,
  input  logic [CNT_W-1:0]  len_i,
  output logic [DATA_W-1:0] val_o,
  output logic [CNT_W-1:0]  len_o
);
  localparam int unsigned HALF = SPAN / 2;

  logic upper_hit;

  always_comb begin
    upper_hit = |val_i[SPAN-1:HALF];
    if (upper_hit) begin
      val_o = val_i >> HALF;
      len_o = len_i - CNT_W'(HALF);
    end else begin
      val_o = val_i;
      len_o = len_i;
    end
  end
endmodule

// File: rtl/lbc_nibble_sig.sv
module lbc_nibble_sig (
  input  logic [3:0] nib_i,
  output logic [2:0] sig_o
);
  always_comb begin
    if (nib_i[3])      sig_o = 3'd4;
    else if (nib_i[2]) sig_o = 3'd3;
    else if (nib_i[1]) sig_o = 3'd2;
    else if (nib_i[0]) sig_o = 3'd1;
    else               sig_o = 3'd0;
  end
endmodule

// File: rtl/lbc_zero_core.sv
module lbc_zero_core #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = $clog2(DATA_W) + 1
) (
  input  logic [DATA_W-1:0] data_i,
  output logic [CNT_W-1:0]  count_o
);
  localparam int unsigned NSTAGE = $clog2(DATA_W) - 2;

  logic [DATA_W-1:0] val_chain [NSTAGE+1];
  logic [CNT_W-1:0]  len_chain [NSTAGE+1];
  logic [2:0]        nib_sig;

  assign val_chain[0] = data_i;
  assign len_chain[0] = CNT_W'(DATA_W);

  for (genvar k = 0; k < NSTAGE; k++) begin : g_stage
    lbc_halve_stage #(
      .DATA_W(DATA_W),
      .CNT_W (CNT_W),
      .SPAN  (DATA_W >> k)
    ) u_stage (
      .val_i(val_chain[k]),
      .len_i(len_chain[k]),
      .val_o(val_chain[k+1]),
      .len_o(len_chain[k+1])
    );
  end

  lbc_nibble_sig u_nib (
    .nib_i(val_chain[NSTAGE][3:0]),
    .sig_o(nib_sig)
  );

  assign count_o = len_chain[NSTAGE] - CNT_W'(nib_sig);

  always_comb begin
    assert (count_o <= CNT_W'(DATA_W));
    assert (data_i != '0 || count_o == CNT_W'(DATA_W));
    assert (!data_i[DATA_W-1] || count_o == '0);
  end
endmodule

// File: rtl/lead_bit_counter.sv
module lead_bit_counter
  import lbc_pkg::*;
#(
  parameter int unsigned DATA_W = LBC_DATA_W,
  parameter int unsigned FUNC_W = LBC_FUNC_W,
  parameter logic [FUNC_W-1:0] FN_ZEROS = LBC_FN_ZEROS,
  parameter logic [FUNC_W-1:0] FN_ONES  = LBC_FN_ONES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_valid_i,
  input  logic [FUNC_W-1:0] func_i,
  input  logic [DATA_W-1:0] operand_i,
  output logic [DATA_W-1:0] result_o,
  output logic              result_valid_o,
  output logic              illegal_o
);
  localparam int unsigned CNT_W = $clog2(DATA_W) + 1;

  cnt_kind_e         kind;
  logic [DATA_W-1:0] core_in;
  logic [CNT_W-1:0]  core_cnt;
  logic [DATA_W-1:0] next_result;

  always_comb begin
    if (func_i == FN_ZEROS)     kind = CNT_ZEROS;
    else if (func_i == FN_ONES) kind = CNT_ONES;
    else                        kind = CNT_BAD;
  end

  assign core_in = (kind == CNT_ONES) ? ~operand_i : operand_i;

  lbc_zero_core #(
    .DATA_W(DATA_W),
    .CNT_W (CNT_W)
  ) u_core (
    .data_i (core_in),
    .count_o(core_cnt)
  );

  assign next_result = (kind == CNT_BAD) ? '0 : {{(DATA_W-CNT_W){1'b0}}, core_cnt};

  always_ff @(posedge clk) begin
    if (rst) begin
      result_o       <= '0;
      result_valid_o <= 1'b0;
      illegal_o      <= 1'b0;
    end else begin
      result_valid_o <= op_valid_i;
      illegal_o      <= op_valid_i && (kind == CNT_BAD);
      if (op_valid_i) result_o <= next_result;
    end
  end

  p_upper_clear_r5: assert property (@(posedge clk) disable iff (rst)
    result_o[DATA_W-1:CNT_W] == '0);
  p_bad_zero_r6: assert property (@(posedge clk) disable iff (rst)
    illegal_o |-> (result_o == '0));
  p_bad_flag_r6: assert property (@(posedge clk) disable iff (rst)
    (op_valid_i && func_i != FN_ZEROS && func_i != FN_ONES) |=> illegal_o);
  p_valid_rise_r7: assert property (@(posedge clk) disable iff (rst)
    op_valid_i |=> result_valid_o);
  p_good_flag_r7: assert property (@(posedge clk) disable iff (rst)
    (op_valid_i && (func_i == FN_ZEROS || func_i == FN_ONES)) |=> !illegal_o);
  p_idle_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !op_valid_i |=> (!result_valid_o && !illegal_o && $stable(result_o)));
  p_range_r3: assert property (@(posedge clk) disable iff (rst)
    result_o <= DATA_W);
endmodule

// File: tb/lead_bit_counter_test.sv
`timescale 1ns/1ps
module lead_bit_counter_test;
  logic        clk = 1'b0;
  logic        rst;
  logic        op_valid_i;
  logic [5:0]  func_i;
  logic [31:0] operand_i;
  logic [31:0] result_o;
  logic        result_valid_o;
  logic        illegal_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  lead_bit_counter uut (
    .clk(clk), .rst(rst), .op_valid_i(op_valid_i), .func_i(func_i),
    .operand_i(operand_i), .result_o(result_o),
    .result_valid_o(result_valid_o), .illegal_o(illegal_o)
  );

  // {illegal, func, operand, expected}
  localparam int NVEC = 12;
  localparam logic [70:0] VEC [NVEC] = '{
    {1'b0, 6'd32, 32'h0000_0000, 32'd32},
    {1'b0, 6'd33, 32'hFFFF_FFFF, 32'd32},
    {1'b0, 6'd33, 32'hFFFF_0000, 32'd16},
    {1'b0, 6'd32, 32'h0001_0000, 32'd15},
    {1'b0, 6'd32, 32'h0000_00F0, 32'd24},
    {1'b0, 6'd33, 32'hF000_0000, 32'd4},
    {1'b0, 6'd33, 32'h7FFF_FFFF, 32'd0},
    {1'b0, 6'd32, 32'h0000_0001, 32'd31},
    {1'b0, 6'd32, 32'h8000_0000, 32'd0},
    {1'b0, 6'd33, 32'hFFFF_FFFE, 32'd31},
    {1'b1, 6'd5,  32'h0000_1234, 32'd0},
    {1'b1, 6'd34, 32'h0000_0000, 32'd0}
  };

  function automatic int ref_count(input logic [31:0] v, input bit ones);
    int n = 0;
    for (int i = 31; i >= 0; i--) begin
      if (v[i] != ones) break;
      n++;
    end
    return n;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [5:0] fn, input logic [31:0] op);
    @(negedge clk);
    op_valid_i = 1'b1;
    func_i     = fn;
    operand_i  = op;
    @(posedge clk);
    #1;
  endtask

  task automatic go_idle();
    @(negedge clk);
    op_valid_i = 1'b0;
    operand_i  = 32'hA5A5_5A5A;
    func_i     = 6'd5;
    @(posedge clk);
    #1;
  endtask

  task automatic check_fn(input logic [5:0] fn, input logic [31:0] op);
    logic [31:0] e;
    apply(fn, op);
    e = ref_count(op, fn == 6'd33);
    if (fn == 6'd32) check("R3", result_o, e);
    else             check("R4", result_o, e);
    check("R5", {26'd0, result_o[5:0]}, result_o);
    check("R7", {30'd0, result_valid_o, illegal_o}, 32'd2);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] held;
    rst = 1'b1; op_valid_i = 1'b1; func_i = 6'd32; operand_i = 32'h1;
    repeat (3) @(posedge clk);
    #1;
    check("R9 result", result_o, 32'd0);
    check("R9 flags", {30'd0, result_valid_o, illegal_o}, 32'd0);
    @(negedge clk);
    rst = 1'b0; op_valid_i = 1'b0;

    // R1 R2 R3 R4 R6: vector table
    for (int i = 0; i < NVEC; i++) begin
      apply(VEC[i][69:64], VEC[i][63:32]);
      if (VEC[i][70]) begin
        check("R6 flag", {31'd0, illegal_o}, 32'd1);
        check("R6 result", result_o, 32'd0);
      end else if (i == 0) check("R1", result_o, VEC[i][31:0]);
      else if (i == 1)     check("R2", result_o, VEC[i][31:0]);
      else                 check("R3/R4 table", result_o, VEC[i][31:0]);
      check("R7 valid", {31'd0, result_valid_o}, 32'd1);
    end

    // single-bit and inverted single-bit sweeps, both functions
    for (int b = 0; b < 32; b++) begin
      check_fn(6'd32, 32'h1 << b);
      check_fn(6'd33, 32'h1 << b);
      check_fn(6'd33, ~(32'h1 << b));
      check_fn(6'd32, ~(32'h1 << b));
    end

    // random operands, including narrowed-to-a-prefix values
    for (int r = 0; r < 300; r++) begin
      logic [31:0] v;
      v = $urandom;
      if (r % 3 == 1) v = v >> (r % 32);
      if (r % 3 == 2) v = ~(v >> (r % 32));
      check_fn(r[0] ? 6'd33 : 6'd32, v);
    end

    // R8: idle keeps the result and clears the flags
    apply(6'd32, 32'h0000_0100);
    held = result_o;
    check("R3 before idle", held, 32'd23);
    go_idle();
    check("R8 hold", result_o, held);
    check("R8 flags", {30'd0, result_valid_o, illegal_o}, 32'd0);
    go_idle();
    check("R8 hold2", result_o, held);

    // R6 then legal: flag drops
    apply(6'd0, 32'hFFFF_FFFF);
    check("R6 code0", {31'd0, illegal_o}, 32'd1);
    check("R6 code0 result", result_o, 32'd0);
    apply(6'd33, 32'hFFFF_FFFF);
    check("R2 after bad", result_o, 32'd32);
    check("R7 flag low", {31'd0, illegal_o}, 32'd0);

    // R9: reset mid-stream
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #1;
    check("R9 mid", {result_o[29:0], result_valid_o, illegal_o}, 32'd0);
    @(negedge clk); rst = 1'b0; op_valid_i = 1'b0;
    @(posedge clk); #1;

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule